// File: doc/BRIEF.md
# Two-Wire Data FIFO Pair with Threshold Ready Flags

This block sits between a 32-bit register interface and the byte-serial shift engine of a two-wire (I2C) controller. It holds outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO. Software or a DMA engine reaches each FIFO through one holding-register strobe, with either a byte access or a packed word access. A word access moves up to four bytes in one bus cycle, and the lowest byte lane is always the oldest byte.

Each direction has a ready flag that also serves as a DMA request. The flag is compared against a programmable threshold of one, two or four bytes, taken from the mode register. The transmit flag looks at free space and the receive flag looks at stored bytes. A control write selects FIFO operation, flushes either side or performs a software reset. When FIFO operation is off, each side acts as a single-byte holding register with a threshold of one.

The operating mode is held by a two-state machine with states ST_OFF and ST_ON. The transitions are:
- T_ENABLE: ST_OFF to ST_ON, on the enable bit.
- T_DISABLE: ST_ON to ST_OFF, on the disable bit.
- T_SRST: any state to ST_OFF, on the software-reset bit.
- T_HOLD: stay in the current state for every other control write.

Top module: `twi_byte_fifo`

## Requirements
- R1: After reset, FIFO operation is off, both levels are zero, tx_ready is 1, rx_ready is 0, and tx_err and rx_ovr are 0.
- R2: A control write with bit 28 moves ST_OFF to ST_ON. Bit 29 moves ST_ON to ST_OFF, and bit 29 wins when both bits are set. Every change of state empties both FIFOs. Bit 7 is a software reset: it returns to ST_OFF, empties both FIFOs, clears both error flags and sets both threshold codes to 0.
- R3: A transmit byte write pushes wdata[7:0]. In ST_ON, a transmit word write pushes four bytes, which reach the engine in the order wdata[7:0], [15:8], [23:16], [31:24]. eng_tx_byte always shows the oldest byte, and eng_tx_take removes it.
- R4: In ST_ON, a receive word read returns the oldest stored bytes in rdata, up to four of them, with the oldest in [7:0]. Lanes beyond the stored count read as zero. The bytes returned are removed. A receive byte read returns the oldest byte in [7:0], with zero in the upper bits.
- R5: Mode-register write: bits [1:0] set the transmit threshold code and bits [5:4] set the receive threshold code. Code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. In ST_ON, tx_ready is 1 when the free entries are at least the threshold. rx_ready is 1 when the stored bytes are at least the threshold.
- R6: In ST_OFF, each FIFO holds one byte and the threshold is 1 whatever the codes say. A word write stores only wdata[7:0], and a word read returns one byte.
- R7: Control bit 24 empties the transmit FIFO and clears tx_err. Control bit 25 empties the receive FIFO and clears rx_ovr. Neither bit touches the other side.
- R8: level[15:0] holds the transmit byte count and level[31:16] holds the receive byte count.
- R9: A transmit write that does not fit in the free space is dropped whole, including a word write with fewer than four free entries, and tx_err sets. tx_err stays set until a flush or a software reset.
- R10: A byte offered by eng_rx_put while the receive FIFO is full is dropped, and rx_ovr sets. rx_ovr stays set until a flush or a software reset.
- R11: A transmit push and an engine pop in the same cycle both take effect. The space check uses the count from before the cycle. The same rule applies to a receive read and an engine put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe (data on wdata) |
| mode_we | input | 1 | Mode-register write strobe (data on wdata) |
| thr_we | input | 1 | Transmit holding-register write strobe |
| thr_word | input | 1 | Transmit access size: 1 = word, 0 = byte |
| wdata | input | 32 | Write data for all write strobes |
| rhr_re | input | 1 | Receive holding-register read strobe |
| rhr_word | input | 1 | Receive access size: 1 = word, 0 = byte |
| rdata | output | 32 | Receive read data, valid in the strobe cycle |
| level | output | 32 | Receive count [31:16], transmit count [15:0] |
| fifo_on | output | 1 | 1 in ST_ON |
| tx_ready | output | 1 | Transmit threshold met (DMA request) |
| rx_ready | output | 1 | Receive threshold met (DMA request) |
| tx_err | output | 1 | Sticky dropped-write flag |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| eng_tx_take | input | 1 | Engine consumes the oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_rx_put | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |

## Verification
Each strobe sampled at a rising edge changes the stored state at that edge. level, the ready flags, the error flags, fifo_on and eng_tx_byte are decoded from registers, so they are due one edge after the stimulus. The bench compares all of them against its queue model at the following falling edge. rdata is a direct view of the receive FIFO head, so it is checked in the same cycle as its read strobe, before the edge that removes the bytes. Inputs change only on falling edges.

// File: rtl/twi_fifo_pkg.sv
package twi_fifo_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } fifo_state_e;

    localparam int CTL_SRST  = 7;
    localparam int CTL_TXCLR = 24;
    localparam int CTL_RXCLR = 25;
    localparam int CTL_ON    = 28;
    localparam int CTL_OFF   = 29;

    localparam int LANES     = 4;

    // threshold code -> byte count
    function automatic logic [2:0] thr_bytes(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/twi_mode_fsm.sv
module twi_mode_fsm
    import twi_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_data,
    output logic        fifo_on,
    output logic        srst,
    output logic        flush_tx,
    output logic        flush_rx
);

    fifo_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            unique case (state_q)
                ST_OFF: begin
                    if (ctl_data[CTL_SRST])
                        state_d = ST_OFF;                        // T_SRST
                    else if (ctl_data[CTL_ON] && !ctl_data[CTL_OFF])
                        state_d = ST_ON;                         // T_ENABLE
                end
                ST_ON: begin
                    if (ctl_data[CTL_SRST])
                        state_d = ST_OFF;                        // T_SRST
                    else if (ctl_data[CTL_OFF])
                        state_d = ST_OFF;                        // T_DISABLE
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        logic change;
        change   = (state_d != state_q);
        srst     = ctl_we && ctl_data[CTL_SRST];
        flush_tx = srst || change || (ctl_we && ctl_data[CTL_TXCLR]);
        flush_rx = srst || change || (ctl_we && ctl_data[CTL_RXCLR]);
        unique case (state_q)
            ST_ON:   fifo_on = 1'b1;
            default: fifo_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/twi_byte_ring.sv
module twi_byte_ring
    import twi_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [CW-1:0] count,
    output logic [31:0]   peek
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // storage needs no reset; lane k lands at wp+k
    always_ff @(posedge clk) begin
        if (!flush) begin
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < push_n)
                    mem[wp + AW'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign peek[8*g +: 8] = mem[rp + AW'(g)];
    end

endmodule

// File: rtl/twi_ready_gate.sv
module twi_ready_gate
    import twi_fifo_pkg::*;
#(
    parameter int CW    = 6,
    parameter bit IS_TX = 1'b1
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cap,
    input  logic [1:0]    code,
    input  logic          on,
    output logic          ready
);

    logic [2:0] need;
    assign need = on ? thr_bytes(code) : 3'd1;

    if (IS_TX) begin : g_tx
        assign ready = (cap - cnt) >= CW'(need);
    end else begin : g_rx
        assign ready = cnt >= CW'(need);
    end

endmodule

// File: rtl/twi_byte_fifo.sv
module twi_byte_fifo
    import twi_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        mode_we,
    input  logic        thr_we,
    input  logic        thr_word,
    input  logic [31:0] wdata,
    input  logic        rhr_re,
    input  logic        rhr_word,
    output logic [31:0] rdata,
    output logic [31:0] level,
    output logic        fifo_on,
    output logic        tx_ready,
    output logic        rx_ready,
    output logic        tx_err,
    output logic        rx_ovr,
    input  logic        eng_tx_take,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_rx_put,
    input  logic [7:0]  eng_rx_byte
);

    logic          srst, flush_tx, flush_rx;
    logic [1:0]    tx_code, rx_code;
    logic [CW-1:0] cap, tx_cnt, rx_cnt, tx_free;
    logic [2:0]    tx_req, tx_push_n, tx_pop_n;
    logic [2:0]    rd_req, rd_n, rx_push_n, rx_pop_n;
    logic          tx_fits, rx_fits;
    logic [31:0]   tx_peek, rx_peek;

    twi_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_data (wdata),
        .fifo_on  (fifo_on),
        .srst     (srst),
        .flush_tx (flush_tx),
        .flush_rx (flush_rx)
    );

    assign cap = fifo_on ? CW'(DEPTH) : CW'(1);

    // transmit side
    assign tx_free   = cap - tx_cnt;
    assign tx_req    = (thr_word && fifo_on) ? 3'd4 : 3'd1;
    assign tx_fits   = tx_free >= CW'(tx_req);
    assign tx_push_n = (thr_we && tx_fits) ? tx_req : 3'd0;
    assign tx_pop_n  = (eng_tx_take && tx_cnt != '0) ? 3'd1 : 3'd0;

    twi_byte_ring #(.DEPTH(DEPTH)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_tx),
        .push_n    (tx_push_n),
        .push_data (wdata),
        .pop_n     (tx_pop_n),
        .count     (tx_cnt),
        .peek      (tx_peek)
    );

    assign eng_tx_valid = (tx_cnt != '0);
    assign eng_tx_byte  = eng_tx_valid ? tx_peek[7:0] : 8'h00;

    // receive side
    assign rx_fits   = rx_cnt < cap;
    assign rx_push_n = (eng_rx_put && rx_fits) ? 3'd1 : 3'd0;
    assign rd_req    = (rhr_word && fifo_on) ? 3'd4 : 3'd1;
    assign rd_n      = (rx_cnt < CW'(rd_req)) ? rx_cnt[2:0] : rd_req;
    assign rx_pop_n  = rhr_re ? rd_n : 3'd0;

    twi_byte_ring #(.DEPTH(DEPTH)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_rx),
        .push_n    (rx_push_n),
        .push_data ({24'h0, eng_rx_byte}),
        .pop_n     (rx_pop_n),
        .count     (rx_cnt),
        .peek      (rx_peek)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rdata[8*g +: 8] = (3'(g) < rd_n) ? rx_peek[8*g +: 8] : 8'h00;
    end

    // mode register and sticky errors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_code <= 2'd0;
            rx_code <= 2'd0;
        end else if (srst) begin
            tx_code <= 2'd0;
            rx_code <= 2'd0;
        end else if (mode_we) begin
            tx_code <= wdata[1:0];
            rx_code <= wdata[5:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                tx_err <= 1'b0;
        else if (flush_tx)         tx_err <= 1'b0;
        else if (thr_we && !tx_fits) tx_err <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rx_ovr <= 1'b0;
        else if (flush_rx)             rx_ovr <= 1'b0;
        else if (eng_rx_put && !rx_fits) rx_ovr <= 1'b1;
    end

    twi_ready_gate #(.CW(CW), .IS_TX(1'b1)) u_tx_gate (
        .cnt   (tx_cnt),
        .cap   (cap),
        .code  (tx_code),
        .on    (fifo_on),
        .ready (tx_ready)
    );

    twi_ready_gate #(.CW(CW), .IS_TX(1'b0)) u_rx_gate (
        .cnt   (rx_cnt),
        .cap   (cap),
        .code  (rx_code),
        .on    (fifo_on),
        .ready (rx_ready)
    );

    assign level = {16'(rx_cnt), 16'(tx_cnt)};

endmodule

// File: rtl/twi_byte_fifo_chk.sv
module twi_byte_fifo_chk #(
    parameter int DEPTH = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic        thr_we,
    input logic        thr_word,
    input logic [31:0] wdata,
    input logic        eng_tx_take,
    input logic        eng_rx_put,
    input logic [31:0] level,
    input logic        fifo_on,
    input logic        tx_ready,
    input logic        rx_ready,
    input logic        tx_err,
    input logic        rx_ovr
);

    int unsigned cap, txc, rxc;
    assign cap = fifo_on ? DEPTH : 1;
    assign txc = 32'(level[15:0]);
    assign rxc = 32'(level[31:16]);

    // R8: counts never exceed the current capacity
    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (txc <= cap) && (rxc <= cap));

    // R5: receive request never raised on an empty FIFO
    p_rx_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rxc != 0);

    // R6: single-byte holding behaviour when off
    p_off_thresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (tx_ready == (txc == 0)));

    // R7: transmit clear empties the transmit side next cycle
    p_tx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wdata[24]) |=> level[15:0] == 16'h0);

    // R3: a fitting word push adds four bytes
    p_word_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && thr_we && thr_word && !ctl_we && !eng_tx_take && (cap - txc >= 4))
        |=> level[15:0] == $past(level[15:0]) + 16'd4);

    // R10: a byte offered to a full receive side raises overrun
    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_put && rxc == cap && !ctl_we) |=> rx_ovr);

    // R9: tx_err stays set without a control write
    p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !ctl_we) |=> tx_err);

endmodule

bind twi_byte_fifo twi_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .thr_we      (thr_we),
    .thr_word    (thr_word),
    .wdata       (wdata),
    .eng_tx_take (eng_tx_take),
    .eng_rx_put  (eng_rx_put),
    .level       (level),
    .fifo_on     (fifo_on),
    .tx_ready    (tx_ready),
    .rx_ready    (rx_ready),
    .tx_err      (tx_err),
    .rx_ovr      (rx_ovr)
);

// File: tb/twi_byte_fifo_bench.sv
`timescale 1ns/1ps
module twi_byte_fifo_bench;

    localparam int DEPTH = 32;
    localparam time TCK = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 0, mode_we = 0, thr_we = 0, thr_word = 0;
    logic [31:0] wdata = '0;
    logic        rhr_re = 0, rhr_word = 0;
    logic [31:0] rdata, level;
    logic        fifo_on, tx_ready, rx_ready, tx_err, rx_ovr;
    logic        eng_tx_take = 0, eng_tx_valid, eng_rx_put = 0;
    logic [7:0]  eng_tx_byte, eng_rx_byte = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(TCK/2) clk = ~clk;

    twi_byte_fifo #(.DEPTH(DEPTH)) u_twi_byte_fifo (.*);

    // reference model
    byte unsigned tq[$];
    byte unsigned rq[$];
    bit m_on = 0, m_terr = 0, m_rovr = 0;
    int m_tcode = 0, m_rcode = 0;

    function automatic int thr_of(int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        int want, n;
        logic [31:0] v;
        want = (rhr_word && m_on) ? 4 : 1;
        n = (rq.size() < want) ? rq.size() : want;
        v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = rq[k];
        return v;
    endfunction

    task automatic model_edge();
        int cap, tc, rc, n;
        if (ctl_we) begin
            if (wdata[7]) begin
                tq.delete(); rq.delete();
                m_on = 0; m_terr = 0; m_rovr = 0; m_tcode = 0; m_rcode = 0;
                return;
            end
            if (wdata[29] && m_on) begin
                m_on = 0; tq.delete(); rq.delete(); m_terr = 0; m_rovr = 0;
            end else if (wdata[28] && !wdata[29] && !m_on) begin
                m_on = 1; tq.delete(); rq.delete(); m_terr = 0; m_rovr = 0;
            end
            if (wdata[24]) begin tq.delete(); m_terr = 0; end
            if (wdata[25]) begin rq.delete(); m_rovr = 0; end
        end
        if (mode_we) begin
            m_tcode = int'(wdata[1:0]);
            m_rcode = int'(wdata[5:4]);
        end
        cap = m_on ? DEPTH : 1;
        tc = tq.size();
        rc = rq.size();
        if (eng_tx_take && tc > 0) void'(tq.pop_front());
        if (thr_we) begin
            n = (thr_word && m_on) ? 4 : 1;
            if (cap - tc >= n) begin
                for (int k = 0; k < n; k++) tq.push_back(wdata[8*k +: 8]);
            end else m_terr = 1;
        end
        if (rhr_re) begin
            n = (rhr_word && m_on) ? 4 : 1;
            if (n > rc) n = rc;
            for (int k = 0; k < n; k++) void'(rq.pop_front());
        end
        if (eng_rx_put) begin
            if (rc < cap) rq.push_back(eng_rx_byte);
            else m_rovr = 1;
        end
    endtask

    task automatic compare_all();
        int cap, tth, rth;
        cap = m_on ? DEPTH : 1;
        tth = m_on ? thr_of(m_tcode) : 1;
        rth = m_on ? thr_of(m_rcode) : 1;
        chk("R8 level", level, {16'(rq.size()), 16'(tq.size())});
        chk("R5 tx_ready", 32'(tx_ready), 32'((cap - tq.size()) >= tth));
        chk("R5 rx_ready", 32'(rx_ready), 32'(rq.size() >= rth));
        chk("R9 tx_err", 32'(tx_err), 32'(m_terr));
        chk("R10 rx_ovr", 32'(rx_ovr), 32'(m_rovr));
        chk("R2 fifo_on", 32'(fifo_on), 32'(m_on));
        chk("R3 eng_tx_valid", 32'(eng_tx_valid), 32'(tq.size() != 0));
        if (tq.size() != 0) chk("R3 eng_tx_byte", 32'(eng_tx_byte), 32'(tq[0]));
    endtask

    // one cycle: inputs are already driven after a falling edge
    task automatic step();
        #1;
        if (rhr_re) chk("R4 rdata", rdata, exp_rdata());
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        ctl_we = 0; mode_we = 0; thr_we = 0; thr_word = 0; rhr_re = 0;
        rhr_word = 0; eng_tx_take = 0; eng_rx_put = 0;
    endtask

    task automatic ctl(logic [31:0] v);  ctl_we = 1; wdata = v; step(); endtask
    task automatic mode(logic [31:0] v); mode_we = 1; wdata = v; step(); endtask
    task automatic wr_b(logic [7:0] b);  thr_we = 1; thr_word = 0; wdata = {24'hABCDEF, b}; step(); endtask
    task automatic wr_w(logic [31:0] w); thr_we = 1; thr_word = 1; wdata = w; step(); endtask
    task automatic take();               eng_tx_take = 1; step(); endtask
    task automatic put(logic [7:0] b);   eng_rx_put = 1; eng_rx_byte = b; step(); endtask
    task automatic rd(bit word);         rhr_re = 1; rhr_word = word; step(); endtask

    initial begin
        #(TCK * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", level, 32'h0);
        chk("R1 fifo_on", 32'(fifo_on), 32'h0);
        chk("R1 tx_ready", 32'(tx_ready), 32'h1);
        chk("R1 rx_ready", 32'(rx_ready), 32'h0);
        chk("R1 errors", {30'h0, tx_err, rx_ovr}, 32'h0);

        // R6 off: single-byte holding, word write keeps low byte only
        mode(32'h22);
        wr_w(32'h887766A5);
        wr_b(8'h5A);            // R9 dropped, tx_err sets
        take();                 // R3 engine sees A5
        ctl(32'h0100_0000);     // R7 transmit clear
        put(8'h31); put(8'h32); // R10 second byte overruns
        rd(1'b1);               // R6 word read returns one byte
        ctl(32'h0200_0000);     // R7 receive clear

        // R2 enable, R3 little-endian word order
        ctl(32'h1000_0000);
        mode(32'h0);
        wr_w(32'h44332211);
        take(); take(); take(); take();

        // R5 four-byte thresholds; R9 word drop with three free
        mode(32'h22);
        for (int i = 0; i < 7; i++) wr_w(32'h03020100 + 32'(i) * 32'h04040404);
        wr_b(8'hEE);
        wr_w(32'hDEADBEEF);
        // R11 push and pop in one cycle at free = 3
        thr_we = 1; thr_word = 0; wdata = 32'h77; eng_tx_take = 1; step();
        ctl(32'h0100_0000);

        // R4 / R5 receive word reads
        put(8'h01); put(8'h02); put(8'h03); put(8'h04);
        rd(1'b1);
        put(8'h05); put(8'h06);
        rd(1'b1);               // partial word
        mode(32'h10);
        put(8'h07);
        put(8'h08);
        rd(1'b0);
        rd(1'b0);
        rd(1'b0);               // empty byte read
        // R10 overrun at full depth, with same-cycle read (R11)
        for (int i = 0; i < DEPTH; i++) put(8'(i + 16));
        eng_rx_put = 1; eng_rx_byte = 8'hFF; rhr_re = 1; rhr_word = 1; step();
        put(8'hFE);
        ctl(32'h0200_0000);

        // R2 disable empties both; R6 threshold code ignored
        wr_b(8'h12); put(8'h34);
        ctl(32'h3000_0000);     // both bits: disable wins
        put(8'h56);
        wr_b(8'h78);
        // R2 software reset
        mode(32'h22);
        ctl(32'h0000_0080);
        ctl(32'h1000_0000);
        wr_w(32'hCAFEF00D);
        ctl(32'h0000_0080);
        chk("R1 after soft reset", level, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule